// File: doc/BRIEF.md
# Hybrid Additive Cellular Automaton Pattern Generator

This block is an n-cell, two-state cellular automaton for on-chip test pattern generation. Each cell is one flip-flop. On every advancing clock edge all cells update together. A cell's new value is the XOR of any chosen subset of three inputs: its left neighbour, itself and its right neighbour. A per-cell complement flag turns that XOR into XNOR. The three selection bits of every cell form a banded (tridiagonal) dependency matrix over GF(2). The array has null boundaries: the missing neighbour of each end cell reads as 0.

The rule is fixed at elaboration time through parameters. It is chosen so that the machine is a non-maximal-length group automaton. The default configuration is a 7-cell rule made of two uncoupled maximal-length sections, one of 4 cells and one of 3 cells. Because 15 and 7 are coprime, any state with both sections nonzero lies on one target cycle of 105 states. Every state in which a whole section is zero lies on a separate short cycle. A walk started on the target cycle therefore never produces those patterns, so they can serve as the forbidden set.

A synchronous reset loads a parameterised nonzero seed. A load strobe places a user seed into the register. An advance enable steps the automaton. The parallel pattern output is the register itself.

Top module: `ca_tpg`

## Requirements
- R1: While `rst` is high at a rising edge, the register takes the parameter `SEED`. With the defaults this is 7'b0010001 (cells 0 and 4 set). Reset has priority over load and advance.
- R2: When `ld` is high and `rst` is low at a rising edge, the register takes `seed_i`, even if `adv` is also high.
- R3: When `rst`, `ld` and `adv` are all low at a rising edge, `pat_o` keeps its value.
- R4: When `adv` is high and `rst` and `ld` are low, the next value is computed per cell. Bit i of `pat_o` is cell i. Cell i becomes the XOR of the neighbours it selects: bit i of `DEP_L` selects cell i-1, bit i of `DEP_S` selects cell i itself, and bit i of `DEP_R` selects cell i+1. The result is complemented when bit i of `INV` is 1. The left input of cell 0 and the right input of cell N-1 read 0.
- R5: The 5-cell reference rule is supported exactly, with bit j of each row mask denoting column j. Its row masks are 00001, 00110, 01110, 11000 and 10000 (rows 0 to 4). Its complement vector is 10101. From seed 00001 its sequence matches the matrix product plus complement.
- R6: Under the default 7-cell rule, the next-state map is a bijection: the 128 states have 128 distinct successors, and every state returns to itself.
- R7: Under the default rule, a seed whose cells 0-3 and cells 4-6 are both nonzero returns to itself after exactly 105 steps, and not earlier.
- R8: Call a pattern forbidden when cells 0-3 are all zero or cells 4-6 are all zero. No forbidden pattern appears during the 105-step walk from seed 7'b0010001.
- R9: Under the default rule, the all-zero state is fixed. A state with only cells 4-6 nonzero has period 7. A state with only cells 0-3 nonzero has period 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all cells update on its rising edge |
| rst | input | 1 | Synchronous active-high reset to `SEED` |
| ld | input | 1 | Load strobe; copies `seed_i` into the cells |
| seed_i | input | N | User seed |
| adv | input | 1 | Advance enable; steps the automaton one generation |
| pat_o | output | N | Current pattern, taken straight from the cell register |

## Verification
The assertions assume that `rst`, `ld`, `adv` and `seed_i` are free of X after the first edge. They also assume the inputs only change between rising edges, so that the value sampled with `$past` is the one the register acted on. The stimulus meets both assumptions: it drives every input from one process at falling edges, and it starts from a defined value on each input. The step check compares the register against a row-by-row model built from the same parameter vectors. That check is only meaningful when the vectors describe a banded rule. Both configurations in the bench are banded.

// File: rtl/ca_tpg_pkg.sv
package ca_tpg_pkg;

    // Neighbour selection and complement flag of a single cell.
    typedef struct packed {
        logic use_l;
        logic use_s;
        logic use_r;
        logic invert;
    } cell_rule_t;

    // Register action for one clock edge, listed from lowest to highest priority.
    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_STEP,
        UPD_LOAD,
        UPD_RESET
    } upd_e;

    function automatic logic cell_eval(cell_rule_t r, logic l, logic s, logic rt);
        return (r.use_l & l) ^ (r.use_s & s) ^ (r.use_r & rt) ^ r.invert;
    endfunction

    function automatic upd_e pick_update(logic rst, logic ld, logic adv);
        if (rst)      return UPD_RESET;
        else if (ld)  return UPD_LOAD;
        else if (adv) return UPD_STEP;
        else          return UPD_HOLD;
    endfunction

endpackage

// File: rtl/ca_next_logic.sv
module ca_next_logic
    import ca_tpg_pkg::*;
#(
    parameter int          N     = 7,
    parameter logic [N-1:0] DEP_L = '0,
    parameter logic [N-1:0] DEP_S = '0,
    parameter logic [N-1:0] DEP_R = '0,
    parameter logic [N-1:0] INV   = '0
) (
    input  logic [N-1:0] cur_i,
    output logic [N-1:0] nxt_o
);
    localparam int PW = N + 2;

    // Null boundary: zero on both ends, so padded[i], padded[i+1] and
    // padded[i+2] are the left, self and right inputs of cell i.
    logic [PW-1:0] padded;
    assign padded = {1'b0, cur_i, 1'b0};

    for (genvar i = 0; i < N; i++) begin : g_cell
        localparam cell_rule_t RULE = '{
            use_l:  DEP_L[i],
            use_s:  DEP_S[i],
            use_r:  DEP_R[i],
            invert: INV[i]
        };
        assign nxt_o[i] = cell_eval(RULE, padded[i], padded[i+1], padded[i+2]);
    end
endmodule

// File: rtl/ca_state_reg.sv
module ca_state_reg
    import ca_tpg_pkg::*;
#(
    parameter int           N    = 7,
    parameter logic [N-1:0] SEED = '0
) (
    input  logic         clk,
    input  upd_e         upd_i,
    input  logic [N-1:0] seed_i,
    input  logic [N-1:0] nxt_i,
    output logic [N-1:0] q_o
);
    always_ff @(posedge clk) begin
        case (upd_i)
            UPD_RESET: q_o <= SEED;
            UPD_LOAD:  q_o <= seed_i;
            UPD_STEP:  q_o <= nxt_i;
            default:   q_o <= q_o;
        endcase
    end
endmodule

// File: rtl/ca_tpg.sv
module ca_tpg
    import ca_tpg_pkg::*;
#(
    parameter int           N     = 7,
    parameter logic [N-1:0] DEP_L = 7'b1101110,
    parameter logic [N-1:0] DEP_S = 7'b1101010,
    parameter logic [N-1:0] DEP_R = 7'b0110111,
    parameter logic [N-1:0] INV   = 7'b0000000,
    parameter logic [N-1:0] SEED  = 7'b0010001
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [N-1:0] seed_i,
    input  logic         adv,
    output logic [N-1:0] pat_o
);
    upd_e         upd;
    logic [N-1:0] state;
    logic [N-1:0] nxt;

    assign upd = pick_update(rst, ld, adv);

    ca_next_logic #(
        .N(N), .DEP_L(DEP_L), .DEP_S(DEP_S), .DEP_R(DEP_R), .INV(INV)
    ) u_next (
        .cur_i (state),
        .nxt_o (nxt)
    );

    ca_state_reg #(.N(N), .SEED(SEED)) u_reg (
        .clk    (clk),
        .upd_i  (upd),
        .seed_i (seed_i),
        .nxt_i  (nxt),
        .q_o    (state)
    );

    assign pat_o = state;
endmodule

// File: rtl/ca_tpg_chk.sv
module ca_tpg_chk #(
    parameter int           N     = 7,
    parameter logic [N-1:0] DEP_L = '0,
    parameter logic [N-1:0] DEP_S = '0,
    parameter logic [N-1:0] DEP_R = '0,
    parameter logic [N-1:0] INV   = '0,
    parameter logic [N-1:0] SEED  = '0
) (
    input logic         clk,
    input logic         rst,
    input logic         ld,
    input logic         adv,
    input logic [N-1:0] seed_i,
    input logic [N-1:0] pat_o
);
    // Row-wise view of the banded matrix: row i selects columns i-1, i, i+1.
    logic [N-1:0] exp_next;
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] row;
            row = '0;
            if (DEP_S[i]) row[i] = 1'b1;
            if (DEP_L[i] && i > 0) row[i-1] = 1'b1;
            if (DEP_R[i] && i < N-1) row[i+1] = 1'b1;
            exp_next[i] = (^(row & pat_o)) ^ INV[i];
        end
    end

    // R1
    reset_seed_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pat_o == SEED);

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> pat_o == $past(seed_i));

    // R3
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld && !adv) |=> $stable(pat_o));

    // R4
    step_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld && adv) |=> pat_o == $past(exp_next));
endmodule

bind ca_tpg ca_tpg_chk #(
    .N(N), .DEP_L(DEP_L), .DEP_S(DEP_S), .DEP_R(DEP_R), .INV(INV), .SEED(SEED)
) u_chk (
    .clk(clk), .rst(rst), .ld(ld), .adv(adv), .seed_i(seed_i), .pat_o(pat_o)
);

// File: tb/tb_ca_tpg.sv
module tb_ca_tpg;
    localparam int CLK_PERIOD = 10;

    // Default 7-cell rule, written as row masks (bit j = column j).
    localparam logic [6:0] ROW7 [7] = '{
        7'b0000010, 7'b0000111, 7'b0001010, 7'b0001100,
        7'b0100000, 7'b1110000, 7'b1100000
    };
    // 5-cell reference rule.
    localparam logic [4:0] ROW5 [5] = '{
        5'b00001, 5'b00110, 5'b01110, 5'b11000, 5'b10000
    };
    localparam logic [4:0] F5 = 5'b10101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld = 1'b0, adv = 1'b0;
    logic [6:0] seed = '0;
    logic [6:0] pat;
    logic       ld5 = 1'b0, adv5 = 1'b0;
    logic [4:0] seed5 = '0;
    logic [4:0] pat5;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ca_tpg dut (
        .clk(clk), .rst(rst), .ld(ld), .seed_i(seed), .adv(adv), .pat_o(pat)
    );

    ca_tpg #(
        .N(5), .DEP_L(5'b00100), .DEP_S(5'b11111), .DEP_R(5'b01110),
        .INV(5'b10101), .SEED(5'b00001)
    ) dut_ref (
        .clk(clk), .rst(rst), .ld(ld5), .seed_i(seed5), .adv(adv5), .pat_o(pat5)
    );

    function automatic logic [6:0] m7(logic [6:0] s);
        logic [6:0] r;
        for (int i = 0; i < 7; i++) r[i] = ^(ROW7[i] & s);
        return r;
    endfunction

    function automatic logic [4:0] m5(logic [4:0] s);
        logic [4:0] r;
        for (int i = 0; i < 5; i++) r[i] = (^(ROW5[i] & s)) ^ F5[i];
        return r;
    endfunction

    function automatic int period7(logic [6:0] s);
        if (s[3:0] == 0 && s[6:4] == 0) return 1;
        if (s[3:0] == 0) return 7;
        if (s[6:4] == 0) return 15;
        return 15 * 7;
    endfunction

    function automatic bit forbidden7(logic [6:0] s);
        return (s[3:0] == 0) || (s[6:4] == 0);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load7(logic [6:0] s);
        @(negedge clk);
        ld = 1'b1; seed = s; adv = 1'b0;
        @(negedge clk);
        ld = 1'b0;
    endtask

    initial begin
        logic [127:0] seen;
        logic [6:0]   list [6];
        logic [4:0]   e5;
        int           ret;
        int           distinct;
        list = '{7'h00, 7'h10, 7'h70, 7'h01, 7'h0F, 7'h50};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state of both instances
        chk(pat == 7'b0010001, "R1", pat, 7'b0010001);
        chk(pat5 == 5'b00001, "R1", pat5, 5'b00001);

        // R3 hold with advance low
        repeat (3) @(negedge clk);
        chk(pat == 7'b0010001, "R3", pat, 7'b0010001);
        chk(pat5 == 5'b00001, "R3", pat5, 5'b00001);

        // R5 reference rule walk
        e5 = 5'b00001;
        adv5 = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            e5 = m5(e5);
            chk(pat5 == e5, "R5", pat5, e5);
        end
        adv5 = 1'b0;
        @(negedge clk);
        chk(pat5 == e5, "R3", pat5, e5);

        // R2 load takes priority over advance
        @(negedge clk);
        ld = 1'b1; adv = 1'b1; seed = 7'h55;
        @(negedge clk);
        ld = 1'b0; adv = 1'b0;
        chk(pat == 7'h55, "R2", pat, 7'h55);

        // R4 / R6 successor of every state
        seen = '0;
        for (int s = 0; s < 128; s++) begin
            load7(7'(s));
            adv = 1'b1;
            @(negedge clk);
            adv = 1'b0;
            chk(pat == m7(7'(s)), "R4", pat, m7(7'(s)));
            seen[pat] = 1'b1;
        end
        distinct = $countones(seen);
        chk(distinct == 128, "R6", distinct, 128);

        // R6 / R9 / R7 period of every state
        for (int s = 0; s < 128; s++) begin
            load7(7'(s));
            adv = 1'b1;
            ret = 0;
            for (int k = 1; k <= 110 && ret == 0; k++) begin
                @(negedge clk);
                if (pat == 7'(s)) ret = k;
            end
            adv = 1'b0;
            chk(ret == period7(7'(s)), "R9", ret, period7(7'(s)));
        end

        // R7 / R8 target-cycle walk from the reset seed
        load7(7'b0010001);
        adv = 1'b1;
        ret = 0;
        for (int k = 1; k <= 105; k++) begin
            @(negedge clk);
            if (pat == 7'b0010001 && ret == 0) ret = k;
            chk(!forbidden7(pat), "R8", pat, 0);
            for (int j = 0; j < 6; j++)
                chk(pat != list[j], "R8", pat, list[j]);
        end
        adv = 1'b0;
        chk(ret == 105, "R7", ret, 105);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule